// File: doc/BRIEF.md
# Critical-Doubleword-First Line Refill Engine

This block refills one 32-byte cache line from a 64-bit system bus. The cache controller hands it a miss, given as a doubleword address and the way chosen for replacement. The engine then issues a single burst read. The burst begins at the doubleword that missed, so the first of the four 64-bit beats carries the data the requester is waiting for. Each beat is written into the data array in the cycle it arrives. The first beat is also forwarded to the requester in that same cycle. The later beats wrap around the line modulo four, so a line never reaches past its own aligned 32-byte block.

Only one refill is in flight at a time. While a refill is in progress, a busy output holds off further misses. Meanwhile the cache keeps serving hits on other lines. Accesses to the line being refilled go through a probe port. That port reports whether the requested doubleword has already landed in the engine's line buffer, and returns it if so, or tells the access to stall. The tag and valid bit are not written during the fill. Instead, a one-cycle completion pulse after the last beat carries the way and line to be marked valid.

Top module: `line_fill_engine`

## Requirements
- R1: When `miss_valid_i` is high while `miss_busy_o` is low, `bus_req_o` is high for exactly one cycle, in the next cycle. In that cycle `bus_addr_o` equals the miss doubleword address shifted left by 3, with the low three bits at zero.
- R2: Let c be miss address bits [1:0], the doubleword index within the line. Beat k (k = 0..3) is written to doubleword index (c + k) mod 4, shown on `arr_wr_dw_o`.
- R3: Each beat accepted during a fill raises `arr_wr_en_o` in the same cycle as `bus_beat_valid_i`. In that cycle `arr_wr_data_o` equals the beat data, `arr_wr_way_o` equals the captured way, and `arr_wr_line_o` equals miss address bits [28:2].
- R4: `fwd_valid_o` is high only in the cycle of the first beat of a fill, with `fwd_data_o` equal to that beat's data. It is high once per fill.
- R5: `miss_busy_o` is high from the cycle after acceptance through the completion cycle. A miss presented while busy starts no burst, and no `bus_req_o` follows once the fill ends if that miss was withdrawn.
- R6: `fill_done_o` is high for exactly one cycle, the cycle after the fourth beat, with `done_way_o` and `done_line_o` naming the way and line written. `miss_busy_o` is low in the following cycle.
- R7: While busy, a probe (`probe_valid_i`) on the same line gives `probe_buf_hit_o` = 1 and `probe_data_o` = that doubleword's beat data if it has already been received. If it has not, the probe gives `probe_stall_o` = 1. A probe on any other line raises neither output.
- R8: Idle cycles between beats (`bus_beat_valid_i` low) write nothing and do not advance the beat order.
- R9: After reset, `miss_busy_o`, `bus_req_o`, `arr_wr_en_o`, `fwd_valid_o`, `fill_done_o`, `probe_stall_o` and `probe_buf_hit_o` are all low.
- R10: `bus_beat_valid_i` is ignored when idle and in the request cycle: no array write and no forward result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | Miss request present |
| miss_addr_i | input | 29 | Missed doubleword address (byte address bits [31:3]) |
| miss_way_i | input | 3 | Way to refill |
| miss_busy_o | output | 1 | Refill in progress, new misses are held off |
| bus_req_o | output | 1 | One-cycle burst read request |
| bus_addr_o | output | 32 | Burst start byte address (critical doubleword) |
| bus_beat_valid_i | input | 1 | Beat data valid on the bus |
| bus_beat_data_i | input | 64 | Beat data |
| arr_wr_en_o | output | 1 | Data array write strobe |
| arr_wr_way_o | output | 3 | Data array write way |
| arr_wr_line_o | output | 27 | Data array write line address |
| arr_wr_dw_o | output | 2 | Doubleword index within the line |
| arr_wr_data_o | output | 64 | Data array write data |
| fwd_valid_o | output | 1 | Critical doubleword forward strobe |
| fwd_data_o | output | 64 | Forwarded doubleword |
| probe_valid_i | input | 1 | Internal access probe |
| probe_addr_i | input | 29 | Probe doubleword address |
| probe_stall_o | output | 1 | Probe targets a doubleword not yet received |
| probe_buf_hit_o | output | 1 | Probe served from the line buffer |
| probe_data_o | output | 64 | Line buffer data for the probe |
| fill_done_o | output | 1 | One-cycle fill completion pulse |
| done_way_o | output | 3 | Way completed, to be marked valid |
| done_line_o | output | 27 | Line completed, to be tagged |

## Verification
The assertions assume that the bus delivers exactly four beats per burst, and that none of them arrive before the cycle after `bus_req_o`. The write-count and wrap-step properties depend on this. The stimulus keeps within that limit for every fill. It does also drive a beat in the request cycle and when idle, since that beat must leave no trace at the ports. The assertions also take it that a miss source whose miss was not accepted either keeps it raised or withdraws it. The withdrawal case is driven deliberately, so that no late burst can appear after completion.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_BEAT = 2'd2,
    ST_DONE = 2'd3
  } fill_state_e;
endpackage

// File: rtl/lfe_ctrl.sv
module lfe_ctrl
  import lfe_pkg::*;
#(
  parameter int LINE_BEATS = 4,
  parameter int IDX_W      = $clog2(LINE_BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_valid_i,
  input  logic             beat_valid_i,
  output logic             accept_o,
  output logic             beat_fire_o,
  output logic             first_beat_o,
  output logic [IDX_W-1:0] beat_cnt_o,
  output logic             busy_o,
  output logic             req_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(LINE_BEATS - 1);

  fill_state_e      state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (miss_valid_i) state_d = ST_REQ;
      ST_REQ: begin
        state_d = ST_BEAT;
        cnt_d   = '0;
      end
      ST_BEAT: if (beat_valid_i) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_CNT) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign accept_o     = (state_q == ST_IDLE) && miss_valid_i;
  assign beat_fire_o  = (state_q == ST_BEAT) && beat_valid_i;
  assign first_beat_o = beat_fire_o && (cnt_q == '0);
  assign beat_cnt_o   = cnt_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign req_o        = (state_q == ST_REQ);
  assign done_o       = (state_q == ST_DONE);
endmodule

// File: rtl/lfe_order.sv
module lfe_order #(
  parameter int LINE_BEATS = 4,
  parameter int IDX_W      = $clog2(LINE_BEATS)
) (
  input  logic [IDX_W-1:0] crit_i,
  input  logic [IDX_W-1:0] cnt_i,
  output logic [IDX_W-1:0] dw_o
);
  generate
    if ((1 << IDX_W) == LINE_BEATS) begin : g_pow2
      // natural wrap of the index width
      assign dw_o = crit_i + cnt_i;
    end else begin : g_mod
      logic [IDX_W:0] sum;
      assign sum  = {1'b0, crit_i} + {1'b0, cnt_i};
      assign dw_o = (sum >= (IDX_W+1)'(LINE_BEATS)) ?
                    IDX_W'(sum - (IDX_W+1)'(LINE_BEATS)) : sum[IDX_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/lfe_line_buf.sv
module lfe_line_buf #(
  parameter int DATA_W     = 64,
  parameter int LINE_BEATS = 4,
  parameter int IDX_W      = $clog2(LINE_BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_have_o
);
  logic [LINE_BEATS-1:0][DATA_W-1:0] slot_data;
  logic [LINE_BEATS-1:0]             slot_have;

  generate
    for (genvar s = 0; s < LINE_BEATS; s++) begin : g_slot
      logic [DATA_W-1:0] data_q;
      logic              have_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          data_q <= '0;
          have_q <= 1'b0;
        end else if (clr_i) begin
          have_q <= 1'b0;
        end else if (wr_i && (wr_idx_i == IDX_W'(s))) begin
          data_q <= wr_data_i;
          have_q <= 1'b1;
        end
      end
      assign slot_data[s] = data_q;
      assign slot_have[s] = have_q;
    end
  endgenerate

  assign rd_data_o = slot_data[rd_idx_i];
  assign rd_have_o = slot_have[rd_idx_i];
endmodule

// File: rtl/lfe_probe.sv
module lfe_probe #(
  parameter int LINE_W = 27
) (
  input  logic              probe_valid_i,
  input  logic              active_i,
  input  logic [LINE_W-1:0] probe_line_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              have_i,
  output logic              stall_o,
  output logic              hit_o
);
  logic same_line;
  assign same_line = probe_valid_i && active_i && (probe_line_i == fill_line_i);
  assign stall_o   = same_line && !have_i;
  assign hit_o     = same_line && have_i;
endmodule

// File: rtl/line_fill_engine.sv
module line_fill_engine #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BEATS = 4,
  parameter int WAYS       = 8,
  localparam int OFF_W     = $clog2(DATA_W / 8),
  localparam int IDX_W     = $clog2(LINE_BEATS),
  localparam int DWA_W     = ADDR_W - OFF_W,
  localparam int LINE_W    = DWA_W - IDX_W,
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [DWA_W-1:0]  miss_addr_i,
  input  logic [WAY_W-1:0]  miss_way_i,
  output logic              miss_busy_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_beat_valid_i,
  input  logic [DATA_W-1:0] bus_beat_data_i,
  output logic              arr_wr_en_o,
  output logic [WAY_W-1:0]  arr_wr_way_o,
  output logic [LINE_W-1:0] arr_wr_line_o,
  output logic [IDX_W-1:0]  arr_wr_dw_o,
  output logic [DATA_W-1:0] arr_wr_data_o,
  output logic              fwd_valid_o,
  output logic [DATA_W-1:0] fwd_data_o,
  input  logic              probe_valid_i,
  input  logic [DWA_W-1:0]  probe_addr_i,
  output logic              probe_stall_o,
  output logic              probe_buf_hit_o,
  output logic [DATA_W-1:0] probe_data_o,
  output logic              fill_done_o,
  output logic [WAY_W-1:0]  done_way_o,
  output logic [LINE_W-1:0] done_line_o
);
  logic             accept, beat_fire, first_beat, busy, req, done;
  logic [IDX_W-1:0] beat_cnt, wr_dw;
  logic [DWA_W-1:0] fill_dwa_q;
  logic [WAY_W-1:0] fill_way_q;
  logic [LINE_W-1:0] fill_line;
  logic [IDX_W-1:0] crit_idx;
  logic             buf_have;

  lfe_ctrl #(.LINE_BEATS(LINE_BEATS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_valid_i (miss_valid_i),
    .beat_valid_i (bus_beat_valid_i),
    .accept_o     (accept),
    .beat_fire_o  (beat_fire),
    .first_beat_o (first_beat),
    .beat_cnt_o   (beat_cnt),
    .busy_o       (busy),
    .req_o        (req),
    .done_o       (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_dwa_q <= '0;
      fill_way_q <= '0;
    end else if (accept) begin
      fill_dwa_q <= miss_addr_i;
      fill_way_q <= miss_way_i;
    end
  end

  assign fill_line = fill_dwa_q[DWA_W-1:IDX_W];
  assign crit_idx  = fill_dwa_q[IDX_W-1:0];

  lfe_order #(.LINE_BEATS(LINE_BEATS), .IDX_W(IDX_W)) u_order (
    .crit_i (crit_idx),
    .cnt_i  (beat_cnt),
    .dw_o   (wr_dw)
  );

  lfe_line_buf #(.DATA_W(DATA_W), .LINE_BEATS(LINE_BEATS), .IDX_W(IDX_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .wr_i      (beat_fire),
    .wr_idx_i  (wr_dw),
    .wr_data_i (bus_beat_data_i),
    .rd_idx_i  (probe_addr_i[IDX_W-1:0]),
    .rd_data_o (probe_data_o),
    .rd_have_o (buf_have)
  );

  lfe_probe #(.LINE_W(LINE_W)) u_probe (
    .probe_valid_i (probe_valid_i),
    .active_i      (busy),
    .probe_line_i  (probe_addr_i[DWA_W-1:IDX_W]),
    .fill_line_i   (fill_line),
    .have_i        (buf_have),
    .stall_o       (probe_stall_o),
    .hit_o         (probe_buf_hit_o)
  );

  assign miss_busy_o   = busy;
  assign bus_req_o     = req;
  assign bus_addr_o    = {fill_dwa_q, {OFF_W{1'b0}}};
  // beat goes to the array and the requester in its arrival cycle
  assign arr_wr_en_o   = beat_fire;
  assign arr_wr_way_o  = fill_way_q;
  assign arr_wr_line_o = fill_line;
  assign arr_wr_dw_o   = wr_dw;
  assign arr_wr_data_o = bus_beat_data_i;
  assign fwd_valid_o   = first_beat;
  assign fwd_data_o    = bus_beat_data_i;
  assign fill_done_o   = done;
  assign done_way_o    = fill_way_q;
  assign done_line_o   = fill_line;
endmodule

// File: rtl/lfe_checker.sv
module lfe_checker #(
  parameter int DATA_W     = 64,
  parameter int LINE_BEATS = 4,
  parameter int IDX_W      = $clog2(LINE_BEATS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic              miss_busy_o,
  input logic              bus_req_o,
  input logic [IDX_W-1:0]  crit_i,
  input logic              arr_wr_en_o,
  input logic [IDX_W-1:0]  arr_wr_dw_o,
  input logic [DATA_W-1:0] arr_wr_data_o,
  input logic              fwd_valid_o,
  input logic [DATA_W-1:0] fwd_data_o,
  input logic              fill_done_o,
  input logic              probe_stall_o,
  input logic              probe_buf_hit_o
);
  localparam int CW = $clog2(LINE_BEATS + 1);

  logic [CW-1:0]    wr_cnt_q;
  logic [IDX_W-1:0] last_dw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q  <= '0;
      last_dw_q <= '0;
    end else begin
      if (bus_req_o)        wr_cnt_q <= '0;
      else if (arr_wr_en_o) wr_cnt_q <= wr_cnt_q + 1'b1;
      if (arr_wr_en_o)      last_dw_q <= arr_wr_dw_o;
    end
  end

  assert_req_after_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && !miss_busy_o) |=> (bus_req_o && miss_busy_o));

  assert_first_at_crit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (arr_wr_dw_o == crit_i));

  assert_wrap_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_wr_en_o && !fwd_valid_o) |-> (arr_wr_dw_o == IDX_W'(last_dw_q + 1'b1)));

  assert_fwd_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (arr_wr_en_o && (fwd_data_o == arr_wr_data_o) && (wr_cnt_q == '0)));

  assert_no_req_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_busy_o && !bus_req_o) |=> !bus_req_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |=> (!fill_done_o && !miss_busy_o));

  assert_done_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |-> (wr_cnt_q == CW'(LINE_BEATS)));

  assert_probe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(probe_stall_o && probe_buf_hit_o));

  assert_wr_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_en_o |-> (miss_busy_o && !bus_req_o && !fill_done_o));
endmodule

bind line_fill_engine lfe_checker #(
  .DATA_W     (DATA_W),
  .LINE_BEATS (LINE_BEATS),
  .IDX_W      (IDX_W)
) u_lfe_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .miss_valid_i    (miss_valid_i),
  .miss_busy_o     (miss_busy_o),
  .bus_req_o       (bus_req_o),
  .crit_i          (bus_addr_o[OFF_W +: IDX_W]),
  .arr_wr_en_o     (arr_wr_en_o),
  .arr_wr_dw_o     (arr_wr_dw_o),
  .arr_wr_data_o   (arr_wr_data_o),
  .fwd_valid_o     (fwd_valid_o),
  .fwd_data_o      (fwd_data_o),
  .fill_done_o     (fill_done_o),
  .probe_stall_o   (probe_stall_o),
  .probe_buf_hit_o (probe_buf_hit_o)
);

// File: tb/line_fill_engine_test.sv
module line_fill_engine_test;
  typedef struct packed {
    logic [28:0] dwa;
    logic [2:0]  way;
    logic [3:0]  gaps;
    logic [15:0] seed;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{dwa: 29'h0012_3450, way: 3'd0, gaps: 4'b0000, seed: 16'h1111},
    '{dwa: 29'h0012_3455, way: 3'd1, gaps: 4'b0000, seed: 16'h2222},
    '{dwa: 29'h0ABC_DEF6, way: 3'd5, gaps: 4'b1010, seed: 16'h3333},
    '{dwa: 29'h1FFF_FFFF, way: 3'd7, gaps: 4'b0101, seed: 16'h4444},
    '{dwa: 29'h0000_0002, way: 3'd3, gaps: 4'b1111, seed: 16'h5555},
    '{dwa: 29'h0765_4327, way: 3'd6, gaps: 4'b0110, seed: 16'h6666}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic [28:0] miss_addr_i = '0;
  logic [2:0]  miss_way_i = '0;
  logic        miss_busy_o, bus_req_o;
  logic [31:0] bus_addr_o;
  logic        bus_beat_valid_i = 1'b0;
  logic [63:0] bus_beat_data_i = '0;
  logic        arr_wr_en_o;
  logic [2:0]  arr_wr_way_o;
  logic [26:0] arr_wr_line_o;
  logic [1:0]  arr_wr_dw_o;
  logic [63:0] arr_wr_data_o;
  logic        fwd_valid_o;
  logic [63:0] fwd_data_o;
  logic        probe_valid_i = 1'b0;
  logic [28:0] probe_addr_i = '0;
  logic        probe_stall_o, probe_buf_hit_o;
  logic [63:0] probe_data_o;
  logic        fill_done_o;
  logic [2:0]  done_way_o;
  logic [26:0] done_line_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  line_fill_engine uut (
    .clk_i, .rst_ni, .miss_valid_i, .miss_addr_i, .miss_way_i, .miss_busy_o,
    .bus_req_o, .bus_addr_o, .bus_beat_valid_i, .bus_beat_data_i,
    .arr_wr_en_o, .arr_wr_way_o, .arr_wr_line_o, .arr_wr_dw_o, .arr_wr_data_o,
    .fwd_valid_o, .fwd_data_o, .probe_valid_i, .probe_addr_i, .probe_stall_o,
    .probe_buf_hit_o, .probe_data_o, .fill_done_o, .done_way_o, .done_line_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_data(input logic [15:0] seed, input int k,
                                            input logic [1:0] dw, input logic [28:0] dwa);
    return {seed, 16'(k), 14'd0, dw, dwa[15:0]};
  endfunction

  task automatic run_fill(input vec_t v, input bit do_probe, input bit hold_other);
    logic [1:0] crit = v.dwa[1:0];
    @(negedge clk_i);
    miss_valid_i = 1'b1; miss_addr_i = v.dwa; miss_way_i = v.way;
    #1 chk("R1 busy low at accept", 64'(miss_busy_o), 64'd0);
    @(negedge clk_i);
    miss_valid_i = hold_other; miss_addr_i = v.dwa ^ 29'h100;
    bus_beat_valid_i = 1'b1; bus_beat_data_i = 64'hDEAD_BEEF_DEAD_BEEF;
    #1;
    chk("R1 bus_req", 64'(bus_req_o), 64'd1);
    chk("R1 bus_addr", 64'(bus_addr_o), 64'({v.dwa, 3'b000}));
    chk("R5 busy after accept", 64'(miss_busy_o), 64'd1);
    chk("R10 no write in req cycle", 64'(arr_wr_en_o), 64'd0);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] dw = crit + 2'(k);
      if (v.gaps[k]) begin
        @(negedge clk_i);
        bus_beat_valid_i = 1'b0; bus_beat_data_i = 64'hFFFF_0000_FFFF_0000;
        #1 chk("R8 no write in gap", 64'({arr_wr_en_o, fwd_valid_o}), 64'd0);
      end
      if (do_probe && k == 2) begin
        @(negedge clk_i);
        bus_beat_valid_i = 1'b0;
        probe_valid_i = 1'b1; probe_addr_i = {v.dwa[28:2], crit};
        #1;
        chk("R7 received hit", 64'({probe_buf_hit_o, probe_stall_o}), 64'b10);
        chk("R7 received data", probe_data_o, beat_data(v.seed, 0, crit, v.dwa));
        probe_addr_i = {v.dwa[28:2], crit + 2'd2};
        #1 chk("R7 pending stall", 64'({probe_buf_hit_o, probe_stall_o}), 64'b01);
        probe_addr_i = v.dwa ^ 29'h40;
        #1 chk("R7 other line", 64'({probe_buf_hit_o, probe_stall_o}), 64'b00);
        probe_valid_i = 1'b0;
      end
      @(negedge clk_i);
      bus_beat_valid_i = 1'b1; bus_beat_data_i = beat_data(v.seed, k, dw, v.dwa);
      #1;
      chk("R3 write strobe", 64'(arr_wr_en_o), 64'd1);
      chk("R2 write index", 64'(arr_wr_dw_o), 64'(dw));
      chk("R3 write data", arr_wr_data_o, beat_data(v.seed, k, dw, v.dwa));
      chk("R3 write way/line", 64'({arr_wr_way_o, arr_wr_line_o}), 64'({v.way, v.dwa[28:2]}));
      chk("R4 forward strobe", 64'(fwd_valid_o), 64'(k == 0));
      if (k == 0) chk("R4 forward data", fwd_data_o, beat_data(v.seed, 0, dw, v.dwa));
      if (hold_other) chk("R5 no req while busy", 64'(bus_req_o), 64'd0);
    end
    @(negedge clk_i);
    bus_beat_valid_i = 1'b0; miss_valid_i = 1'b0;
    #1;
    chk("R6 done pulse", 64'(fill_done_o), 64'd1);
    chk("R6 done way/line", 64'({done_way_o, done_line_o}), 64'({v.way, v.dwa[28:2]}));
    chk("R10 no write at done", 64'(arr_wr_en_o), 64'd0);
    @(negedge clk_i);
    #1;
    chk("R6 done single cycle", 64'({fill_done_o, miss_busy_o}), 64'd0);
    chk("R5 no req after fill", 64'(bus_req_o), 64'd0);
  endtask

  initial begin
    fork
      begin
        #20;
        #1;
        chk("R9 reset outputs", 64'({miss_busy_o, bus_req_o, arr_wr_en_o, fwd_valid_o,
                                     fill_done_o, probe_stall_o, probe_buf_hit_o}), 64'd0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        bus_beat_valid_i = 1'b1; bus_beat_data_i = 64'h0123_4567_89AB_CDEF;
        probe_valid_i = 1'b1; probe_addr_i = 29'h0;
        #1;
        chk("R10 idle beat ignored", 64'({arr_wr_en_o, fwd_valid_o}), 64'd0);
        chk("R7 idle probe", 64'({probe_buf_hit_o, probe_stall_o}), 64'd0);
        chk("R9 idle stays", 64'({miss_busy_o, fill_done_o}), 64'd0);
        @(negedge clk_i);
        bus_beat_valid_i = 1'b0; probe_valid_i = 1'b0;
        for (int i = 0; i < NV; i++) run_fill(VEC[i], 1'b0, 1'b0);
        run_fill(VEC[2], 1'b1, 1'b0);
        run_fill(VEC[3], 1'b0, 1'b1);
        run_fill(VEC[5], 1'b1, 1'b1);
        @(negedge clk_i);
        #1 chk("R5 idle after withdrawn miss", 64'({bus_req_o, miss_busy_o}), 64'd0);
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule